// File: doc/BRIEF.md
# Memory Region Unmap and Write-Protect Gate

This block sits between a CPU and its 64 KB RAM and decides, for every memory cycle, whether the RAM takes part in it. The address space is cut into sixteen 4 KB regions, and bits 15:12 of the CPU address select the region. Two 16-bit write-only masks control the RAM. The first is the unmap mask: a set bit removes the region from RAM, so that something else on the bus can answer there. The second is the protect mask: a set bit lets the region be read but blocks writes to it.

Software loads each mask one byte at a time over the I/O write bus. The block performs no address translation. The address handed to the RAM is the CPU address, unchanged. The RAM enable and the RAM write enable follow the CPU strobes combinationally. A mask update takes effect from the first cycle after the clock edge that samples the I/O write.

Top module: `mem_guard`

## Requirements
- R1: After reset is asserted, both masks are all zero. Every region then drives ram_en_o on a read or write cycle, and drives ram_we_o on a write cycle.
- R2: The region index is addr_i[15:12]. Mask bit n controls region n, so region 0 starts at address 0x0000 and region 15 starts at 0xF000.
- R3: An I/O write to port 0xF8 loads unmap mask bits 7:0 from io_data_i. An I/O write to port 0xF9 loads bits 15:8. The other byte keeps its value.
- R4: An I/O write to port 0xFA loads protect mask bits 7:0 from io_data_i. An I/O write to port 0xFB loads bits 15:8. The other byte keeps its value.
- R5: In a region whose unmap bit is 1, ram_en_o and ram_we_o stay low on both read and write cycles, whatever the protect bit is.
- R6: In a mapped region whose protect bit is 1, a read or write cycle drives ram_en_o high and ram_we_o low.
- R7: ram_en_o is high only when mreq_i is high together with rd_i or wr_i. ram_we_o is high only when ram_en_o and wr_i are both high.
- R8: ram_addr_o always equals addr_i.
- R9: An I/O write to any port other than 0xF8 to 0xFB leaves both masks unchanged. A cycle with io_wr_i low also leaves both masks unchanged, whatever is on the I/O address and data.
- R10: A mask load takes effect at the clock edge where io_wr_i is sampled high. A memory cycle presented during that same clock period still sees the old mask. A memory cycle presented right after that edge sees the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU memory address |
| mreq_i | input | 1 | Memory request strobe, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| io_wr_i | input | 1 | I/O write strobe, active high, sampled on clk_i |
| io_addr_i | input | 8 | I/O port number |
| io_data_i | input | 8 | I/O write data |
| ram_en_o | output | 1 | RAM enable for the current cycle |
| ram_we_o | output | 1 | RAM write enable for the current cycle |
| ram_addr_o | output | 16 | Address passed to the RAM |

## Verification
Two situations are hard to reach from the ports. The first is a memory cycle that overlaps the clock period in which a mask byte is being loaded. The bench produces it by driving a memory access and an I/O write in the same period, and expects the old mask. It then checks the very next access against the new mask. The second is proving that stray I/O writes and idle I/O strobes leave the masks alone. The masks are write-only, so this can only be seen by sweeping accesses across all sixteen regions after the stray traffic, with partial masks already loaded in both bytes.

// File: rtl/mguard_pkg.sv
package mguard_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned REGION_W  = 4;
  localparam int unsigned IO_W      = 8;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned UNMAP_PORT = 'hF8;
  localparam int unsigned PROT_PORT  = 'hFA;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/mguard_io_decode.sv
module mguard_io_decode #(
  parameter int unsigned IO_W       = 8,
  parameter int unsigned MASK_BYTES = 2,
  parameter int unsigned UNMAP_BASE = 'hF8,
  parameter int unsigned PROT_BASE  = 'hFA
) (
  input  logic                  io_wr_i,
  input  logic [IO_W-1:0]       io_addr_i,
  output logic [MASK_BYTES-1:0] unmap_ld_o,
  output logic [MASK_BYTES-1:0] prot_ld_o
);
  // one load strobe per mask byte, byte k at base + k
  for (genvar k = 0; k < MASK_BYTES; k++) begin : g_byte
    localparam logic [IO_W-1:0] UPORT = IO_W'(UNMAP_BASE + k);
    localparam logic [IO_W-1:0] PPORT = IO_W'(PROT_BASE + k);
    assign unmap_ld_o[k] = io_wr_i && (io_addr_i == UPORT);
    assign prot_ld_o[k]  = io_wr_i && (io_addr_i == PPORT);
  end
endmodule

// File: rtl/mguard_mask_reg.sv
module mguard_mask_reg #(
  parameter int unsigned MASK_BYTES = 2,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned MASK_W    = MASK_BYTES * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [MASK_BYTES-1:0] ld_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [MASK_W-1:0]     mask_o
);
  for (genvar k = 0; k < MASK_BYTES; k++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    byte_q <= '0;
      else if (ld_i[k]) byte_q <= data_i;
    end
    assign mask_o[k*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/mguard_region_gate.sv
module mguard_region_gate #(
  parameter int unsigned REGION_W   = 4,
  localparam int unsigned N_REGIONS = 1 << REGION_W
) (
  input  logic [REGION_W-1:0]  region_i,
  input  logic                 mreq_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [N_REGIONS-1:0] unmap_i,
  input  logic [N_REGIONS-1:0] prot_i,
  output logic                 ram_en_o,
  output logic                 ram_we_o
);
  logic cyc;
  logic mapped;
  logic writable;

  always_comb begin
    cyc      = mreq_i & (rd_i | wr_i);
    mapped   = ~unmap_i[region_i];
    writable = ~prot_i[region_i];
    ram_en_o = cyc & mapped;
    ram_we_o = cyc & mapped & wr_i & writable;
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mguard_pkg::*;
#(
  parameter int unsigned P_ADDR_W     = ADDR_W,
  parameter int unsigned P_REGION_W   = REGION_W,
  parameter int unsigned P_IO_W       = IO_W,
  parameter int unsigned P_DATA_W     = DATA_W,
  parameter int unsigned P_UNMAP_PORT = UNMAP_PORT,
  parameter int unsigned P_PROT_PORT  = PROT_PORT,
  localparam int unsigned N_REGIONS   = 1 << P_REGION_W,
  localparam int unsigned MASK_BYTES  = N_REGIONS / P_DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic                mreq_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic                io_wr_i,
  input  logic [P_IO_W-1:0]   io_addr_i,
  input  logic [P_DATA_W-1:0] io_data_i,
  output logic                ram_en_o,
  output logic                ram_we_o,
  output logic [P_ADDR_W-1:0] ram_addr_o
);
  logic [MASK_BYTES-1:0] unmap_ld;
  logic [MASK_BYTES-1:0] prot_ld;
  logic [N_REGIONS-1:0]  unmap_mask;
  logic [N_REGIONS-1:0]  prot_mask;
  logic [P_REGION_W-1:0] region;

  assign region     = addr_i[P_ADDR_W-1 -: P_REGION_W];
  assign ram_addr_o = addr_i; // no translation

  mguard_io_decode #(
    .IO_W(P_IO_W), .MASK_BYTES(MASK_BYTES),
    .UNMAP_BASE(P_UNMAP_PORT), .PROT_BASE(P_PROT_PORT)
  ) u_dec (
    .io_wr_i(io_wr_i), .io_addr_i(io_addr_i),
    .unmap_ld_o(unmap_ld), .prot_ld_o(prot_ld)
  );

  mguard_mask_reg #(.MASK_BYTES(MASK_BYTES), .DATA_W(P_DATA_W)) u_unmap (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(unmap_ld),
    .data_i(io_data_i), .mask_o(unmap_mask)
  );

  mguard_mask_reg #(.MASK_BYTES(MASK_BYTES), .DATA_W(P_DATA_W)) u_prot (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(prot_ld),
    .data_i(io_data_i), .mask_o(prot_mask)
  );

  mguard_region_gate #(.REGION_W(P_REGION_W)) u_gate (
    .region_i(region), .mreq_i(mreq_i), .rd_i(rd_i), .wr_i(wr_i),
    .unmap_i(unmap_mask), .prot_i(prot_mask),
    .ram_en_o(ram_en_o), .ram_we_o(ram_we_o)
  );
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int unsigned P_ADDR_W     = 16,
  parameter int unsigned P_REGION_W   = 4,
  parameter int unsigned P_IO_W       = 8,
  parameter int unsigned P_DATA_W     = 8,
  parameter int unsigned P_UNMAP_PORT = 'hF8,
  parameter int unsigned P_PROT_PORT  = 'hFA,
  localparam int unsigned N_REGIONS   = 1 << P_REGION_W,
  localparam int unsigned MASK_BYTES  = N_REGIONS / P_DATA_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [P_ADDR_W-1:0]  addr_i,
  input logic                 mreq_i,
  input logic                 rd_i,
  input logic                 wr_i,
  input logic                 io_wr_i,
  input logic [P_IO_W-1:0]    io_addr_i,
  input logic [P_DATA_W-1:0]  io_data_i,
  input logic                 ram_en_o,
  input logic                 ram_we_o,
  input logic [P_ADDR_W-1:0]  ram_addr_o,
  input logic [N_REGIONS-1:0] unmap_mask,
  input logic [N_REGIONS-1:0] prot_mask
);
  logic [P_REGION_W-1:0] rgn;
  logic                  mask_port;
  assign rgn = addr_i[P_ADDR_W-1 -: P_REGION_W];
  assign mask_port = ((io_addr_i - P_IO_W'(P_UNMAP_PORT)) < P_IO_W'(MASK_BYTES)) ||
                     ((io_addr_i - P_IO_W'(P_PROT_PORT))  < P_IO_W'(MASK_BYTES));

  // R5
  unmapped_no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> !unmap_mask[rgn]);

  // R6
  protected_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (wr_i && ram_en_o && !prot_mask[rgn]));

  // R6
  read_allowed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && rd_i && !unmap_mask[rgn]) |-> ram_en_o);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mreq_i && (rd_i || wr_i)) |-> !(ram_en_o || ram_we_o));

  // R8
  addr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_addr_o == addr_i);

  // R9
  stray_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_wr_i || !mask_port) |=> ($stable(unmap_mask) && $stable(prot_mask)));

  for (genvar k = 0; k < MASK_BYTES; k++) begin : g_ld
    // R3
    unmap_byte_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (io_wr_i && io_addr_i == P_IO_W'(P_UNMAP_PORT + k)) |=>
        (unmap_mask[k*P_DATA_W +: P_DATA_W] == $past(io_data_i)) && $stable(prot_mask));
    // R4
    prot_byte_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (io_wr_i && io_addr_i == P_IO_W'(P_PROT_PORT + k)) |=>
        (prot_mask[k*P_DATA_W +: P_DATA_W] == $past(io_data_i)) && $stable(unmap_mask));
  end
endmodule

bind mem_guard mem_guard_chk #(
  .P_ADDR_W(P_ADDR_W), .P_REGION_W(P_REGION_W), .P_IO_W(P_IO_W),
  .P_DATA_W(P_DATA_W), .P_UNMAP_PORT(P_UNMAP_PORT), .P_PROT_PORT(P_PROT_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .mreq_i(mreq_i),
  .rd_i(rd_i), .wr_i(wr_i), .io_wr_i(io_wr_i), .io_addr_i(io_addr_i),
  .io_data_i(io_data_i), .ram_en_o(ram_en_o), .ram_we_o(ram_we_o),
  .ram_addr_o(ram_addr_o), .unmap_mask(unmap_mask), .prot_mask(prot_mask)
);

// File: tb/mem_guard_bench.sv
`timescale 1ns/1ps
module mem_guard_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        mreq_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic        io_wr_i = 1'b0;
  logic [7:0]  io_addr_i = '0, io_data_i = '0;
  logic        ram_en_o, ram_we_o;
  logic [15:0] ram_addr_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_unmap = '0, m_prot = '0;

  typedef struct {
    string       tag;
    logic [15:0] a;
    logic        en;
    logic        we;
  } exp_t;
  exp_t q[$];

  always #4 clk_i = ~clk_i;

  mem_guard u_mem_guard (.*);

  function automatic exp_t predict(string tag, logic [15:0] a, logic m, logic r, logic w);
    exp_t e;
    logic cyc;
    cyc  = m && (r || w);
    e.tag = tag;
    e.a  = a;
    e.en = cyc && !m_unmap[a[15:12]];
    e.we = e.en && w && !m_prot[a[15:12]];
    return e;
  endfunction

  task automatic drive_acc(string tag, logic [15:0] a, logic m, logic r, logic w);
    addr_i = a; mreq_i = m; rd_i = r; wr_i = w;
    q.push_back(predict(tag, a, m, r, w));
  endtask

  task automatic access(string tag, logic [15:0] a, logic m, logic r, logic w);
    @(posedge clk_i); #1;
    drive_acc(tag, a, m, r, w);
  endtask

  task automatic model_load(logic [7:0] p, logic [7:0] d);
    case (p)
      8'hF8: m_unmap[7:0]  = d;
      8'hF9: m_unmap[15:8] = d;
      8'hFA: m_prot[7:0]   = d;
      8'hFB: m_prot[15:8]  = d;
      default: ;
    endcase
  endtask

  // I/O write held one period; probe access in that period sees the old mask
  task automatic io_write(logic [7:0] p, logic [7:0] d, bit strobe, bit probe,
                          string tag, logic [15:0] a, logic r, logic w);
    @(posedge clk_i); #1;
    io_wr_i = strobe; io_addr_i = p; io_data_i = d;
    if (probe) drive_acc(tag, a, 1'b1, r, w);
    else begin mreq_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0; end
    @(posedge clk_i); #1;
    io_wr_i = 1'b0;
    if (strobe) model_load(p, d);
    mreq_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 16; i++) begin
      access(tag, 16'(i * 16'h1000 + 16'h0123), 1'b1, 1'b1, 1'b0);
      access(tag, 16'(i * 16'h1000 + 16'h0ABC), 1'b1, 1'b0, 1'b1);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ram_en_o !== e.en || ram_we_o !== e.we || ram_addr_o !== e.a) begin
          fails++;
          $display("FAIL %s addr=%h: actual en=%b we=%b a=%h expected en=%b we=%b a=%h",
                   e.tag, e.a, ram_en_o, ram_we_o, ram_addr_o, e.en, e.we, e.a);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 R2: reset state, all regions enabled and writable
    sweep("R1");
    // R7: strobe qualification
    access("R7", 16'h2000, 1'b0, 1'b1, 1'b0);
    access("R7", 16'h2000, 1'b0, 1'b0, 1'b1);
    access("R7", 16'h2000, 1'b1, 1'b0, 1'b0);
    access("R7", 16'h2000, 1'b1, 1'b1, 1'b0);
    // R8
    access("R8", 16'hBEEF, 1'b1, 1'b1, 1'b0);
    access("R8", 16'h0000, 1'b0, 1'b0, 1'b0);

    // R10 + R3: probe region 0 during load (old), then new mask
    io_write(8'hF8, 8'h05, 1, 1, "R10", 16'h0010, 1'b1, 1'b0);
    access("R10", 16'h0010, 1'b1, 1'b1, 1'b0);
    // R5: unmapped on reads and writes; R2 boundary 0x0FFF/0x1000/0x2000
    access("R5", 16'h0FFF, 1'b1, 1'b0, 1'b1);
    access("R2", 16'h1000, 1'b1, 1'b0, 1'b1);
    access("R5", 16'h2000, 1'b1, 1'b1, 1'b0);
    // R3: high byte, low byte retained
    io_write(8'hF9, 8'h80, 1, 0, "", 16'h0, 1'b0, 1'b0);
    access("R3", 16'hFFFF, 1'b1, 1'b1, 1'b0);
    access("R3", 16'hEFFF, 1'b1, 1'b0, 1'b1);
    access("R3", 16'h0000, 1'b1, 1'b1, 1'b0);
    // R4 + R6: protect
    io_write(8'hFA, 8'h02, 1, 1, "R10", 16'h1234, 1'b0, 1'b1);
    access("R6", 16'h1234, 1'b1, 1'b0, 1'b1);
    access("R6", 16'h1234, 1'b1, 1'b1, 1'b0);
    io_write(8'hFB, 8'h01, 1, 0, "", 16'h0, 1'b0, 1'b0);
    access("R4", 16'h8000, 1'b1, 1'b0, 1'b1);
    access("R4", 16'h1FFF, 1'b1, 1'b0, 1'b1);
    sweep("R4");

    // R9: stray ports and idle strobe
    io_write(8'hE4, 8'hFF, 1, 0, "", 16'h0, 1'b0, 1'b0);
    io_write(8'hF0, 8'hFF, 1, 0, "", 16'h0, 1'b0, 1'b0);
    io_write(8'hF7, 8'hFF, 1, 0, "", 16'h0, 1'b0, 1'b0);
    io_write(8'hFC, 8'hFF, 1, 0, "", 16'h0, 1'b0, 1'b0);
    io_write(8'hFF, 8'hFF, 1, 0, "", 16'h0, 1'b0, 1'b0);
    io_write(8'hF8, 8'hFF, 0, 0, "", 16'h0, 1'b0, 1'b0);
    io_write(8'hFA, 8'hFF, 0, 0, "", 16'h0, 1'b0, 1'b0);
    sweep("R9");

    // R5: unmap wins over protect; clearing unmap leaves protect
    io_write(8'hFA, 8'h03, 1, 0, "", 16'h0, 1'b0, 1'b0);
    access("R5", 16'h0400, 1'b1, 1'b0, 1'b1);
    io_write(8'hF8, 8'h00, 1, 1, "R10", 16'h0400, 1'b0, 1'b1);
    access("R6", 16'h0400, 1'b1, 1'b0, 1'b1);
    access("R6", 16'h0400, 1'b1, 1'b1, 1'b0);
    io_write(8'hF9, 8'hFF, 1, 0, "", 16'h0, 1'b0, 1'b0);
    io_write(8'hFB, 8'hFF, 1, 0, "", 16'h0, 1'b0, 1'b0);
    sweep("R5");

    // R1: reset mid-run clears both masks
    @(posedge clk_i); #1 rst_ni = 1'b0;
    m_unmap = '0; m_prot = '0;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    sweep("R1");

    repeat (2) @(posedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule